// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a processor pipeline and a 32-bit data memory that is addressed by words. For each access it adds a sign-extended 16-bit displacement to a 32-bit base value to form the byte address. It checks that the address is aligned for the access size and then issues one memory request. For a store it moves the low byte, the low halfword or the full word of the source value onto the byte lanes that the address selects, and it raises the matching byte enables. For a load it records the size, the signedness and the low address bits. When the memory returns the word one cycle later, the unit picks out the addressed lanes and extends them to 32 bits.

Lanes are big-endian. Byte offset 0 is data bits 31:24, offset 1 is bits 23:16, offset 2 is bits 15:8 and offset 3 is bits 7:0. An access that is not aligned for its size goes no further. The unit raises an error flag in the same cycle and sends nothing to memory.

Top module: `lsu_lane_steer`

## Requirements
- R1: The byte address is `base_addr` plus `offset` read as a signed 16-bit value, wrapping modulo 2^32. `mem_addr` carries this address with bits 1:0 forced to 0, in the same cycle as the request.
- R2: `req_kind` is encoded as 0 word, 1 signed halfword, 2 unsigned halfword, 3 signed byte, 4 unsigned byte, and codes 5 to 7 act as word. A word store drives `mem_be`=1111 and passes `store_data` through unchanged.
- R3: A halfword store (kind 1 or 2) puts `store_data[15:0]` on bits 31:16 with `mem_be`=1100 when address bit 1 is 0, and on bits 15:0 with `mem_be`=0011 when it is 1. All other lanes of `mem_wdata` are zero.
- R4: A byte store (kind 3 or 4) puts `store_data[7:0]` on the lane for address bits 1:0 under the big-endian mapping. It sets only that lane's enable (1000, 0100, 0010, 0001 for offsets 0 to 3), and all other lanes are zero.
- R5: An access is misaligned when it is a word access with address bits 1:0 not 00, or a halfword access with bit 0 set. A misaligned access raises `align_err` in the same cycle, with `mem_req`=0, `mem_we`=0 and `mem_be`=0000. Byte accesses are never misaligned.
- R6: An issued load (`mem_req`=1, `mem_we`=0) raises `load_valid` for exactly the following cycle. `load_result` is then derived combinationally from `mem_rdata` in that cycle. A store or a rejected access does not raise `load_valid`.
- R7: A byte load returns the lane named by its address bits 1:0. Kind 3 sign-extends that byte and kind 4 zero-extends it.
- R8: A halfword load returns bits 31:16 when address bit 1 is 0 and bits 15:0 when it is 1. Kind 1 sign-extends and kind 2 zero-extends.
- R9: A word load returns `mem_rdata` unchanged. Loads drive the same lane enables as stores of the same size.
- R10: After reset, `load_valid` is 0. While `req_valid` is 0, `mem_req`, `mem_we`, `align_err` and `mem_be` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_store | input | 1 | 1 for store, 0 for load |
| req_kind | input | 3 | Size and signedness code |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| store_data | input | 32 | Source register for stores |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Issued access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Lane enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_rdata | input | 32 | Read word, one cycle after the request |
| load_valid | output | 1 | Load result valid this cycle |
| load_result | output | 32 | Extended load value |
| align_err | output | 1 | Misaligned access rejected |

## Verification
Stores are driven at all four byte offsets and at both halfword positions. The source value has distinct bytes in every lane, so a lane swap or a lane that should be cleared but is not shows up in the write data and the enables. Loads return a word whose selected lanes have the top bit set and a word whose selected lanes have it clear, which separates sign extension from zero extension for each kind. Word and halfword requests at each illegal offset, together with byte requests at odd offsets, separate the two alignment rules from each other. A negative displacement that crosses a word boundary and a base that wraps past the top of the address space check the displacement arithmetic.

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [2:0]       req_kind,
  input  logic [31:0]      base_addr,
  input  logic [OFS_W-1:0] offset,
  input  logic [31:0]      store_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             load_valid,
  output logic [31:0]      load_result,
  output logic             align_err
);
  localparam logic [2:0] K_HS = 3'd1, K_HU = 3'd2, K_BS = 3'd3, K_BU = 3'd4;

  logic [31:0] eff_addr;
  logic [1:0]  lo;
  logic        is_half, is_byte, is_word, misal, issue;
  logic [3:0]  lane_mask;
  logic [31:0] steer_data;

  assign eff_addr = base_addr + {{(32-OFS_W){offset[OFS_W-1]}}, offset};
  assign lo       = eff_addr[1:0];
  assign is_half  = (req_kind == K_HS) || (req_kind == K_HU);
  assign is_byte  = (req_kind == K_BS) || (req_kind == K_BU);
  assign is_word  = !is_half && !is_byte;

  assign misal = req_valid && ((is_word && (lo != 2'b00)) || (is_half && lo[0]));
  assign issue = req_valid && !misal;

  always_comb begin
    if (is_byte) begin
      lane_mask  = 4'b1000 >> lo;
      steer_data = {store_data[7:0], 24'h0} >> {lo, 3'b000};
    end else if (is_half) begin
      lane_mask  = lo[1] ? 4'b0011 : 4'b1100;
      steer_data = lo[1] ? {16'h0, store_data[15:0]} : {store_data[15:0], 16'h0};
    end else begin
      lane_mask  = 4'b1111;
      steer_data = store_data;
    end
  end

  assign mem_req   = issue;
  assign mem_we    = issue && req_store;
  assign mem_addr  = {eff_addr[31:2], 2'b00};
  assign mem_be    = issue ? lane_mask : 4'b0000;
  assign mem_wdata = (issue && req_store) ? steer_data : 32'h0;
  assign align_err = misal;

  logic       ld_pend;
  logic [2:0] ld_kind;
  logic [1:0] ld_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_pend <= 1'b0;
      ld_kind <= 3'd0;
      ld_lo   <= 2'b00;
    end else begin
      ld_pend <= issue && !req_store;
      if (issue && !req_store) begin
        ld_kind <= req_kind;
        ld_lo   <= lo;
      end
    end
  end

  logic [31:0] byte_shift;
  logic [7:0]  sel_byte;
  logic [15:0] sel_half;

  assign byte_shift = mem_rdata >> {~ld_lo, 3'b000};
  assign sel_byte   = byte_shift[7:0];
  assign sel_half   = ld_lo[1] ? mem_rdata[15:0] : mem_rdata[31:16];

  always_comb begin
    case (ld_kind)
      K_HS:    load_result = {{16{sel_half[15]}}, sel_half};
      K_HU:    load_result = {16'h0, sel_half};
      K_BS:    load_result = {{24{sel_byte[7]}}, sel_byte};
      K_BU:    load_result = {24'h0, sel_byte};
      default: load_result = mem_rdata;
    endcase
  end

  assign load_valid = ld_pend;
endmodule

// File: rtl/lsu_lane_steer_chk.sv
module lsu_lane_steer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic        load_valid,
  input logic        align_err
);
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_req && !mem_we && mem_be == 4'b0000)); // R5
  AST_ADDR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R1
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4)); // R4
  AST_WE_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req); // R2
  AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> load_valid); // R6
  AST_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !mem_we) |=> !load_valid); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!mem_req && !align_err && mem_be == 4'b0000)); // R10
endmodule

bind lsu_lane_steer lsu_lane_steer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
  .load_valid(load_valid), .align_err(align_err)
);

// File: tb/test_lsu_lane_steer.sv
module test_lsu_lane_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [31:0] base_addr = 32'h0, store_data = 32'h0, mem_rdata = 32'h0;
  logic [15:0] offset = 16'h0;
  logic        mem_req, mem_we, load_valid, align_err;
  logic [31:0] mem_addr, mem_wdata, load_result;
  logic [3:0]  mem_be;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  lsu_lane_steer i_lsu_lane_steer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_kind(req_kind), .base_addr(base_addr), .offset(offset),
    .store_data(store_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .load_valid(load_valid), .load_result(load_result),
    .align_err(align_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic st, input logic [2:0] k, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_kind = k;
    base_addr = b; offset = o; store_data = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
    #1;
  endtask

  task automatic do_store(input string tag, input logic [2:0] k, input logic [31:0] b,
                          input logic [15:0] o, input logic [31:0] d,
                          input logic [31:0] ea, input logic [3:0] be, input logic [31:0] wd);
    drive(1'b1, k, b, o, d);
    chk({tag, " req"}, {31'h0, mem_req && mem_we}, 32'h1);
    chk({tag, " addr"}, mem_addr, ea);
    chk({tag, " be"}, {28'h0, mem_be}, {28'h0, be});
    chk({tag, " wdata"}, mem_wdata, wd);
    idle();
    chk({tag, " no load_valid"}, {31'h0, load_valid}, 32'h0);
  endtask

  task automatic do_load(input string tag, input logic [2:0] k, input logic [31:0] b,
                         input logic [15:0] o, input logic [3:0] be,
                         input logic [31:0] rd, input logic [31:0] exp);
    drive(1'b0, k, b, o, 32'h0);
    chk({tag, " req"}, {30'h0, mem_req, mem_we}, 32'h2);
    chk({tag, " be"}, {28'h0, mem_be}, {28'h0, be});
    @(negedge clk);
    req_valid = 1'b0; mem_rdata = rd;
    #1;
    chk({tag, " valid"}, {31'h0, load_valid}, 32'h1);
    chk({tag, " result"}, load_result, exp);
    @(negedge clk); #1;
    chk({tag, " valid drops"}, {31'h0, load_valid}, 32'h0);
  endtask

  task automatic do_misal(input string tag, input logic st, input logic [2:0] k,
                          input logic [31:0] b, input logic [15:0] o);
    drive(st, k, b, o, 32'hFFFF_FFFF);
    chk({tag, " err"}, {31'h0, align_err}, 32'h1);
    chk({tag, " quiet"}, {26'h0, mem_req, mem_we, mem_be}, 32'h0);
    idle();
    chk({tag, " no load_valid"}, {31'h0, load_valid}, 32'h0);
  endtask

  task automatic t_reset();
    chk("R10 reset load_valid", {31'h0, load_valid}, 32'h0);
    chk("R10 idle outputs", {28'h0, mem_req, mem_we, align_err, |mem_be}, 32'h0);
  endtask

  task automatic t_stores();
    do_store("R2 word store", 3'd0, 32'h0000_1000, 16'h0008, 32'hA1B2_C3D4, 32'h0000_1008, 4'b1111, 32'hA1B2_C3D4);
    do_store("R2 kind7 as word", 3'd7, 32'h0000_1000, 16'h0004, 32'h1234_5678, 32'h0000_1004, 4'b1111, 32'h1234_5678);
    do_store("R3 half hi", 3'd1, 32'h0000_2000, 16'h0000, 32'hAAAA_5566, 32'h0000_2000, 4'b1100, 32'h5566_0000);
    do_store("R3 half lo", 3'd2, 32'h0000_2000, 16'h0002, 32'hAAAA_5566, 32'h0000_2000, 4'b0011, 32'h0000_5566);
    for (int i = 0; i < 4; i++)
      do_store("R4 byte lane", 3'd3, 32'h0000_3000, 16'(i), 32'h1122_33C7,
               32'h0000_3000, 4'b1000 >> i, 32'hC700_0000 >> (8 * i));
  endtask

  task automatic t_addr();
    do_store("R1 negative disp", 3'd4, 32'h0000_1000, 16'hFFFD, 32'h0000_0099, 32'h0000_0FFC, 4'b0100, 32'h0099_0000);
    do_store("R1 wrap", 3'd0, 32'hFFFF_FFF8, 16'h0010, 32'h0000_0001, 32'h0000_0008, 4'b1111, 32'h0000_0001);
  endtask

  task automatic t_misal();
    do_misal("R5 word off1", 1'b1, 3'd0, 32'h100, 16'h1);
    do_misal("R5 word off2", 1'b0, 3'd0, 32'h100, 16'h2);
    do_misal("R5 word off3", 1'b1, 3'd0, 32'h100, 16'h3);
    do_misal("R5 half off1", 1'b0, 3'd1, 32'h100, 16'h1);
    do_misal("R5 half off3", 1'b1, 3'd2, 32'h100, 16'h3);
    drive(1'b0, 3'd3, 32'h101, 16'h0, 32'h0);
    chk("R5 byte odd ok", {30'h0, align_err, mem_req}, 32'h1);
    idle();
  endtask

  task automatic t_loads();
    do_load("R9 word load", 3'd0, 32'h40, 16'h0, 4'b1111, 32'h89AB_CDEF, 32'h89AB_CDEF);
    do_load("R7 sbyte off0 neg", 3'd3, 32'h40, 16'h0, 4'b1000, 32'h8112_3344, 32'hFFFF_FF81);
    do_load("R7 ubyte off0", 3'd4, 32'h40, 16'h0, 4'b1000, 32'h8112_3344, 32'h0000_0081);
    do_load("R7 sbyte off1 pos", 3'd3, 32'h40, 16'h1, 4'b0100, 32'h8112_3344, 32'h0000_0012);
    do_load("R7 sbyte off2 neg", 3'd3, 32'h40, 16'h2, 4'b0010, 32'h00FF_E000, 32'hFFFF_FFE0);
    do_load("R7 ubyte off3", 3'd4, 32'h40, 16'h3, 4'b0001, 32'h0000_00F0, 32'h0000_00F0);
    do_load("R8 shalf hi neg", 3'd1, 32'h40, 16'h0, 4'b1100, 32'hBEEF_1234, 32'hFFFF_BEEF);
    do_load("R8 uhalf hi", 3'd2, 32'h40, 16'h0, 4'b1100, 32'hBEEF_1234, 32'h0000_BEEF);
    do_load("R8 shalf lo pos", 3'd1, 32'h40, 16'h2, 4'b0011, 32'hBEEF_1234, 32'h0000_1234);
    do_load("R8 uhalf lo neg", 3'd2, 32'h40, 16'h2, 4'b0011, 32'h0000_F00D, 32'h0000_F00D);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_stores();
    t_addr();
    t_misal();
    t_loads();
    idle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule